// File: doc/BRIEF.md
# Register-Write Command Queue Engine

This engine sits beside a serial-interface peripheral. It reads a list of register writes from a circular buffer in system memory and applies them one by one, so the peripheral can run a sequence of transactions without the processor handling each one. Every queue entry is two 32-bit words: a target address, then a data value. The engine fetches both words through a simple memory read port. It then either presents the pair on a register-write port, or applies it to one of its own registers when the address points back into the engine.

Flow control needs no extra hardware. An entry aimed at the engine's queue-pointer register makes the queue jump, which is how it wraps to the buffer start. An entry aimed at the current-index register marks the end of a transaction block. Software posts work by advancing the end index. When index-equality halting is enabled, the engine stops as soon as the current index catches up with the end index. A small host register file provides enable, a priority field, a software pause, error clearing and status.

Top module: `cmdq_engine`

## Requirements
- R1: An entry is a destination-address word at the queue pointer P followed by a data word at P+4. A destination outside the engine is written once through the write port, and the pointer then advances by 8. Entries are applied strictly in queue order.
- R2: When bit 0 of an entry's address word is set, that bit is cleared before the address is used, and `upd_irq` pulses for exactly one cycle, the cycle after the entry completes. Entries with bit 0 clear raise no pulse.
- R3: An entry whose cleared address equals SELF_BASE+0x4 is not written out. It loads the queue pointer with the entry's data word.
- R4: An entry whose cleared address equals SELF_BASE+0x8 is not written out. It loads the low 8 bits of its data word into the current index, and the pointer advances by 8. The current index changes only through such an entry or a host write.
- R5: The current and end indices are 8 bits wide. STATUS bits [15:8] read (end − current) mod 256.
- R6: When HALT bit 0 is set and the current index equals the end index, no new entry is fetched and STATUS bit 2 (paused) reads 1. A host write that changes the end index lets fetching resume with no other action.
- R7: Clearing CTRL bit 0 (enable) stops fetching at the next entry boundary, and the queue pointer keeps its value. A host write to QPTR takes effect while no entry is in flight, and fetching resumes from that address once the engine is enabled again.
- R8: The host register offsets are 0x0 CTRL ([0] enable, [7:4] priority), 0x1 QPTR, 0x2 CIDX, 0x3 EIDX, 0x4 HALT ([0] index-equality halt enable), 0x5 STATUS (read only: [0] busy, [1] error, [2] paused, [15:8] index gap) and 0x6 CMD (write only). Unused bits read 0.
- R9: A write to CMD with bit 0 set requests a pause, and a write with bit 1 set releases it. A pause only takes effect between entries. While paused, QPTR holds the address of the next entry to be fetched and STATUS bit 2 reads 1.
- R10: A write acknowledged with `wr_err` high sets STATUS bit 1 and stops fetching. QPTR keeps the address of the faulting entry. The error is cleared by a CMD write with bit 2 set, or by a CTRL write with bit 0 clear.
- R11: `wr_req`, `wr_addr` and `wr_data` hold steady until `wr_ack`. No fetch is issued while a write is pending.
- R12: After reset all host registers read 0, and `mem_req`, `wr_req` and `upd_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 3 | Host register word offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| mem_req | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Memory byte address being read |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| wr_req | output | 1 | Register write request, held until `wr_ack` |
| wr_addr | output | 32 | Register write address (bit 0 always 0) |
| wr_data | output | 32 | Register write data |
| wr_ack | input | 1 | Write accepted |
| wr_err | input | 1 | Write failed; valid with `wr_ack` |
| upd_irq | output | 1 | One-cycle update interrupt pulse |

## Verification
Several properties are checked on every clock. Read and write requests hold steady until they complete and never overlap. The written address always has bit 0 clear, and the update pulse never lasts two cycles. No fetch starts while an index-equality halt, a software pause or an error is pending. The current index moves only when an entry or the host loads it. Other behaviour can only be shown by scenarios with a memory and a peripheral model: the order and content of writes across many blocks, wrap-around through a pointer-load entry, the index rolling past 255, the exact pointer value left by a pause or a fault, and recovery after the host moves the pointer.

// File: rtl/cmdq_pkg.sv
// Shared types and the host register map of the command queue engine.
// Assumes a 3-bit word offset on the host port.
package cmdq_pkg;
    typedef logic [2:0] hreg_t;

    localparam hreg_t OFS_CTRL = 3'd0;
    localparam hreg_t OFS_QPTR = 3'd1;
    localparam hreg_t OFS_CIDX = 3'd2;
    localparam hreg_t OFS_EIDX = 3'd3;
    localparam hreg_t OFS_HALT = 3'd4;
    localparam hreg_t OFS_STAT = 3'd5;
    localparam hreg_t OFS_CMD  = 3'd6;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FADDR = 2'd1,
        SQ_FDATA = 2'd2,
        SQ_EXEC  = 2'd3
    } sq_state_t;
endpackage

// File: rtl/cmdq_index_unit.sv
// Current/end index pair of the command queue.
// Host writes win over an engine load in the same cycle; all arithmetic wraps modulo 2**IDX_W.
module cmdq_index_unit #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cur_we,
    input  logic             host_end_we,
    input  logic [IDX_W-1:0] host_val,
    input  logic             eng_cur_load,
    input  logic [IDX_W-1:0] eng_val,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] end_idx,
    output logic             idx_eq,
    output logic [IDX_W-1:0] idx_gap
);
    logic [IDX_W-1:0] cur_q, end_q;

    // Current index: host write first, then engine completion entry.
    always_ff @(posedge clk) begin
        if (!rst_n)            cur_q <= '0;
        else if (host_cur_we)  cur_q <= host_val;
        else if (eng_cur_load) cur_q <= eng_val;
    end

    // End index: host only.
    always_ff @(posedge clk) begin
        if (!rst_n)           end_q <= '0;
        else if (host_end_we) end_q <= host_val;
    end

    assign cur_idx = cur_q;
    assign end_idx = end_q;
    assign idx_eq  = (cur_q == end_q);
    assign idx_gap = end_q - cur_q;

    // R4: current index moves only on a load source
    p_cur_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cur_we && !eng_cur_load) |=> $stable(cur_q));
endmodule

// File: rtl/cmdq_sequencer.sv
// Fetch/execute sequencer: reads address and data words of one entry, then
// applies it internally (pointer or current-index target) or via the write port.
// Assumes SELF_BASE has its low five bits clear and reads complete in the rvalid cycle.
module cmdq_sequencer
    import cmdq_pkg::*;
#(
    parameter int           W         = 32,
    parameter int           IDX_W     = 8,
    parameter logic [W-1:0] SELF_BASE = 32'h4000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             host_ptr_we,
    input  logic [W-1:0]     host_ptr_val,
    output logic             mem_req,
    output logic [W-1:0]     mem_addr,
    input  logic             mem_rvalid,
    input  logic [W-1:0]     mem_rdata,
    output logic             wr_req,
    output logic [W-1:0]     wr_addr,
    output logic [W-1:0]     wr_data,
    input  logic             wr_ack,
    input  logic             wr_err,
    output logic             busy,
    output logic [W-1:0]     fetch_ptr,
    output logic             cur_load,
    output logic [IDX_W-1:0] cur_val,
    output logic             err_set,
    output logic             upd_irq
);
    localparam logic [W-1:0] WSTEP    = W'(W / 8);
    localparam logic [W-1:0] ESTEP    = W'(2 * (W / 8));
    localparam logic [W-1:0] SELF_PTR = SELF_BASE | {{(W-5){1'b0}}, OFS_QPTR, 2'b00};
    localparam logic [W-1:0] SELF_CUR = SELF_BASE | {{(W-5){1'b0}}, OFS_CIDX, 2'b00};

    sq_state_t    state_q;
    logic [W-1:0] ptr_q, eaddr_q, edata_q;
    logic         irq_q;
    logic [W-1:0] tgt;
    logic         hit_ptr, hit_cur, in_exec, ent_done;

    // Decode the latched entry target.
    always_comb begin
        tgt      = {eaddr_q[W-1:1], 1'b0};
        hit_ptr  = (tgt == SELF_PTR);
        hit_cur  = (tgt == SELF_CUR);
        in_exec  = (state_q == SQ_EXEC);
        wr_req   = in_exec && !hit_ptr && !hit_cur;
        err_set  = wr_req && wr_ack && wr_err;
        ent_done = in_exec && (hit_ptr || hit_cur || (wr_ack && !wr_err));
        cur_load = in_exec && hit_cur;
    end

    // Port drive from state.
    always_comb begin
        mem_req  = (state_q == SQ_FADDR) || (state_q == SQ_FDATA);
        mem_addr = (state_q == SQ_FDATA) ? (ptr_q + WSTEP) : ptr_q;
        wr_addr  = tgt;
        wr_data  = edata_q;
        cur_val  = edata_q[IDX_W-1:0];
        busy     = (state_q != SQ_IDLE);
    end

    // Entry state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else begin
            case (state_q)
                SQ_IDLE:  if (go) state_q <= SQ_FADDR;
                SQ_FADDR: if (mem_rvalid) state_q <= SQ_FDATA;
                SQ_FDATA: if (mem_rvalid) state_q <= SQ_EXEC;
                SQ_EXEC:  if (ent_done || err_set) state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    // Queue pointer: host move while idle, jump entry, or advance past a done entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ptr_q <= '0;
        else if (host_ptr_we && state_q == SQ_IDLE)   ptr_q <= host_ptr_val;
        else if (in_exec && hit_ptr)                  ptr_q <= edata_q;
        else if (ent_done)                            ptr_q <= ptr_q + ESTEP;
    end

    // Latch the two words of the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eaddr_q <= '0;
            edata_q <= '0;
        end else begin
            if (state_q == SQ_FADDR && mem_rvalid) eaddr_q <= mem_rdata;
            if (state_q == SQ_FDATA && mem_rvalid) edata_q <= mem_rdata;
        end
    end

    // Update interrupt one cycle after a flagged entry completes.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ent_done && eaddr_q[0];
    end

    assign upd_irq   = irq_q;
    assign fetch_ptr = ptr_q;

    // R1: read address holds until data returns
    p_fetch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R11: pending write holds address and data
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    // R11: no fetch while a write is outstanding
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && wr_req));
    // R2: flag bit never reaches the write port
    p_lsb_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !wr_addr[0]);
    // R2: interrupt is a single-cycle pulse
    p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |=> !upd_irq);
endmodule

// File: rtl/cmdq_engine.sv
// Command queue engine top: host register file, halt/pause/error control,
// index unit and fetch sequencer. Host reads are combinational on hst_addr.
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int           W         = 32,
    parameter int           IDX_W     = 8,
    parameter int           PRI_W     = 4,
    parameter logic [W-1:0] SELF_BASE = 32'h4000_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hst_we,
    input  logic [2:0]   hst_addr,
    input  logic [W-1:0] hst_wdata,
    output logic [W-1:0] hst_rdata,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_rvalid,
    input  logic [W-1:0] mem_rdata,
    output logic         wr_req,
    output logic [W-1:0] wr_addr,
    output logic [W-1:0] wr_data,
    input  logic         wr_ack,
    input  logic         wr_err,
    output logic         upd_irq
);
    logic             en_q, halt_q, swp_q, err_q;
    logic [PRI_W-1:0] prio_q;
    logic             we_ctrl, we_qptr, we_cidx, we_eidx, we_halt, we_cmd;
    logic [IDX_W-1:0] cur_idx, end_idx, idx_gap, cur_val;
    logic             idx_eq, busy, cur_load, err_set, go, paused;
    logic [W-1:0]     fetch_ptr;

    // Host write decode.
    always_comb begin
        we_ctrl = hst_we && (hst_addr == OFS_CTRL);
        we_qptr = hst_we && (hst_addr == OFS_QPTR);
        we_cidx = hst_we && (hst_addr == OFS_CIDX);
        we_eidx = hst_we && (hst_addr == OFS_EIDX);
        we_halt = hst_we && (hst_addr == OFS_HALT);
        we_cmd  = hst_we && (hst_addr == OFS_CMD);
    end

    // Configuration: enable, priority, halt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            prio_q <= '0;
            halt_q <= 1'b0;
        end else begin
            if (we_ctrl) begin
                en_q   <= hst_wdata[0];
                prio_q <= hst_wdata[4 +: PRI_W];
            end
            if (we_halt) halt_q <= hst_wdata[0];
        end
    end

    // Software pause request: set wins over release.
    always_ff @(posedge clk) begin
        if (!rst_n)                       swp_q <= 1'b0;
        else if (we_cmd && hst_wdata[0])  swp_q <= 1'b1;
        else if (we_cmd && hst_wdata[1])  swp_q <= 1'b0;
    end

    // Error flag: set by a failed write, cleared by command or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if ((we_cmd && hst_wdata[2]) || (we_ctrl && !hst_wdata[0])) err_q <= 1'b0;
    end

    // Start condition for the next entry and the paused view.
    always_comb begin
        go     = en_q && !err_q && !swp_q && !(halt_q && idx_eq);
        paused = !busy && (swp_q || (halt_q && idx_eq));
    end

    cmdq_index_unit #(.IDX_W(IDX_W)) u_idx (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_cur_we  (we_cidx),
        .host_end_we  (we_eidx),
        .host_val     (hst_wdata[IDX_W-1:0]),
        .eng_cur_load (cur_load),
        .eng_val      (cur_val),
        .cur_idx      (cur_idx),
        .end_idx      (end_idx),
        .idx_eq       (idx_eq),
        .idx_gap      (idx_gap)
    );

    cmdq_sequencer #(.W(W), .IDX_W(IDX_W), .SELF_BASE(SELF_BASE)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .host_ptr_we  (we_qptr),
        .host_ptr_val (hst_wdata),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_ack       (wr_ack),
        .wr_err       (wr_err),
        .busy         (busy),
        .fetch_ptr    (fetch_ptr),
        .cur_load     (cur_load),
        .cur_val      (cur_val),
        .err_set      (err_set),
        .upd_irq      (upd_irq)
    );

    // Host readback mux.
    always_comb begin
        hst_rdata = '0;
        case (hst_addr)
            OFS_CTRL: begin
                hst_rdata[0]          = en_q;
                hst_rdata[4 +: PRI_W] = prio_q;
            end
            OFS_QPTR: hst_rdata = fetch_ptr;
            OFS_CIDX: hst_rdata[IDX_W-1:0] = cur_idx;
            OFS_EIDX: hst_rdata[IDX_W-1:0] = end_idx;
            OFS_HALT: hst_rdata[0] = halt_q;
            OFS_STAT: begin
                hst_rdata[0]          = busy;
                hst_rdata[1]          = err_q;
                hst_rdata[2]          = paused;
                hst_rdata[8 +: IDX_W] = idx_gap;
            end
            default: hst_rdata = '0;
        endcase
    end

    // R6: index-equality halt blocks the next fetch
    p_halt_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && halt_q && idx_eq) |=> !mem_req);
    // R9: software pause blocks the next fetch
    p_pause_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && swp_q) |=> !mem_req);
    // R10: pending error blocks the next fetch
    p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && err_q) |=> !mem_req);
    // R7: disabled engine starts no fetch
    p_dis_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_q) |=> !mem_req);
endmodule

// File: tb/sim_cmdq_engine.sv
`timescale 1ns/1ps
module sim_cmdq_engine;
    localparam logic [31:0] SB   = 32'h4000_0000;
    localparam logic [31:0] PB   = 32'h1000_0000;
    localparam logic [31:0] ERRA = 32'h1000_003C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_we = 1'b0;
    logic [2:0]  hst_addr = 3'd0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        mem_req, mem_rvalid, wr_req, wr_ack, wr_err, upd_irq;
    logic [31:0] mem_addr, mem_rdata, wr_addr, wr_data;

    logic [31:0] qmem [0:31];
    logic [31:0] la [0:127];
    logic [31:0] ld [0:127];
    logic [31:0] ea [0:127];
    logic [31:0] ed [0:127];
    int lcnt = 0, icnt = 0;
    logic [7:0] cyc = '0;
    int n_chk = 0, n_bad = 0;
    int tail = 0;
    logic [7:0] exp_cur;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    cmdq_engine u0 (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
        .upd_irq(upd_irq)
    );

    // Memory and peripheral models with irregular stalls.
    assign mem_rdata  = qmem[mem_addr[6:2]];
    assign mem_rvalid = mem_req && (cyc[1:0] != 2'b10);
    assign wr_ack     = wr_req && (cyc[2:0] != 3'b011);
    assign wr_err     = wr_ack && (wr_addr == ERRA);

    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (rst_n) begin
            if (wr_req && wr_ack && !wr_err && lcnt < 128) begin
                la[lcnt] <= wr_addr;
                ld[lcnt] <= wr_data;
                lcnt <= lcnt + 1;
            end
            if (upd_irq) icnt <= icnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        hst_addr = a;
        #1 v = hst_rdata;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        qmem[2*tail]   = a;
        qmem[2*tail+1] = d;
        tail++;
    endtask

    task automatic room(input int need);
        if (tail + need + 1 > 16) begin
            put(SB + 32'h4, 32'h0);
            tail = 0;
        end
    endtask

    // Block of nw peripheral writes plus a completion entry; expectations at base eb.
    task automatic make_block(input int nw, input int tag, input bit fl, input int eb, output int start);
        logic [31:0] a;
        room(nw + 1);
        start = tail;
        for (int k = 0; k < nw; k++) begin
            a = PB + 32'(4*k);
            ea[eb+k] = a;
            ed[eb+k] = 32'(tag*256 + k);
            if (fl && k == 0) a = a | 32'h1;
            put(a, 32'(tag*256 + k));
        end
        exp_cur = exp_cur + 8'd1;
        put((SB + 32'h8) | {31'd0, fl}, {24'd0, exp_cur});
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        int n = 0;
        do begin
            hrd(3'd5, v);
            n++;
        end while (!(v[0] == 1'b0 && (v[2] || v[1])) && n < 500);
    endtask

    initial begin
        logic [31:0] v;
        int st, lc0, ic0, nw, dst, dn;
        for (int i = 0; i < 32; i++) qmem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        for (int r = 0; r < 7; r++) begin
            hrd(3'(r), v);
            chk("R12 host register", v, 32'h0);
        end
        chk("R12 outputs", {29'd0, mem_req, wr_req, upd_irq}, 32'h0);

        // R5: modular index gap
        hwr(3'd2, 32'd254); hwr(3'd3, 32'd1);
        hrd(3'd5, v); chk("R5 gap wraps", {24'd0, v[15:8]}, 32'd3);
        hwr(3'd2, 32'd3); hwr(3'd3, 32'd3);
        hrd(3'd5, v); chk("R5 gap zero", {24'd0, v[15:8]}, 32'd0);
        hwr(3'd2, 32'd250); hwr(3'd3, 32'd250);
        exp_cur = 8'd250;

        // R8: field positions
        hwr(3'd4, 32'h1); hwr(3'd0, 32'h51);
        hrd(3'd0, v); chk("R8 ctrl readback", v, 32'h51);
        hrd(3'd4, v); chk("R8 halt readback", v, 32'h1);
        @(negedge clk); @(negedge clk);
        hrd(3'd5, v); chk("R6 R8 paused on equal", v, 32'h4);

        // R1 R2 R3 R4 R5 R6: block sweep with wrap of the buffer and the index
        for (int b = 0; b < 10; b++) begin
            nw = (b % 4) + 1;
            lc0 = lcnt; ic0 = icnt;
            make_block(nw, b + 1, b[0], lc0, st);
            hwr(3'd3, {24'd0, exp_cur});
            wait_stop();
            chk("R1 R6 write count", 32'(lcnt), 32'(lc0 + nw));
            for (int k = 0; k < nw; k++) begin
                chk("R1 R11 address order, R2 bit0 cleared", la[lc0+k], ea[lc0+k]);
                chk("R1 data", ld[lc0+k], ed[lc0+k]);
            end
            hrd(3'd2, v); chk("R4 R5 current index", v, {24'd0, exp_cur});
            hrd(3'd1, v); chk("R3 R1 pointer after block", v, 32'(8*tail));
            chk("R2 interrupt count", 32'(icnt), 32'(ic0 + (b[0] ? 2 : 0)));
        end

        // R9: pause held before start, then mid-block
        lc0 = lcnt;
        make_block(6, 33, 1'b0, lc0, st);
        hwr(3'd6, 32'h1);
        hwr(3'd3, {24'd0, exp_cur});
        repeat (20) @(negedge clk);
        hrd(3'd5, v); chk("R9 paused before start", {29'd0, v[2:0]}, 32'h4);
        chk("R9 nothing written while paused", 32'(lcnt), 32'(lc0));
        hwr(3'd6, 32'h2);
        repeat (9) @(negedge clk);
        hwr(3'd6, 32'h1);
        wait_stop();
        dn = lcnt - lc0;
        hrd(3'd1, v); chk("R9 pointer at next entry", v, 32'(8*(st + dn)));
        chk("R9 stopped inside block", 32'(dn < 6), 32'd1);
        hwr(3'd6, 32'h2);
        wait_stop();
        chk("R9 block finished after release", 32'(lcnt), 32'(lc0 + 6));
        for (int k = 0; k < 6; k++) chk("R9 data after release", ld[lc0+k], ed[lc0+k]);

        // R7: disable, decoy skipped by moving the pointer
        hwr(3'd0, 32'h50);
        lc0 = lcnt;
        room(3);
        dst = tail;
        put(PB + 32'h20, 32'hDEAD_0001);
        put(PB + 32'h24, 32'hDEAD_0002);
        make_block(2, 77, 1'b0, lc0, st);
        hwr(3'd3, {24'd0, exp_cur});
        repeat (20) @(negedge clk);
        chk("R7 no writes while disabled", 32'(lcnt), 32'(lc0));
        hrd(3'd1, v); chk("R7 pointer kept", v, 32'(8*dst));
        hwr(3'd1, 32'(8*st));
        hrd(3'd1, v); chk("R7 host pointer move", v, 32'(8*st));
        hwr(3'd0, 32'h51);
        wait_stop();
        chk("R7 only moved-to block ran", 32'(lcnt), 32'(lc0 + 2));
        chk("R7 first write", la[lc0], PB);
        hrd(3'd2, v); chk("R7 current index", v, {24'd0, exp_cur});

        // R10: fault, hold, recover by clear command
        lc0 = lcnt;
        room(4);
        st = tail;
        put(PB + 32'h30, 32'hA1);
        put(ERRA, 32'hEE);
        put(PB + 32'h34, 32'hA2);
        exp_cur = exp_cur + 8'd1;
        put(SB + 32'h8, {24'd0, exp_cur});
        hwr(3'd3, {24'd0, exp_cur});
        wait_stop();
        hrd(3'd5, v); chk("R10 error flag", {29'd0, v[2:0]}, 32'h2);
        chk("R10 one write before fault", 32'(lcnt), 32'(lc0 + 1));
        hrd(3'd1, v); chk("R10 pointer at faulting entry", v, 32'(8*(st + 1)));
        repeat (30) @(negedge clk);
        hrd(3'd1, v); chk("R10 pointer held", v, 32'(8*(st + 1)));
        chk("R10 no further writes", 32'(lcnt), 32'(lc0 + 1));
        hrd(3'd2, v); chk("R10 index not advanced", v, {24'd0, exp_cur - 8'd1});
        hwr(3'd1, 32'(8*(st + 2)));
        hwr(3'd6, 32'h4);
        wait_stop();
        hrd(3'd5, v); chk("R10 cleared and halted", {29'd0, v[2:0]}, 32'h4);
        chk("R10 resumed write", la[lc0+1], PB + 32'h34);
        hrd(3'd2, v); chk("R10 index after recovery", v, {24'd0, exp_cur});

        // R10: clear by disable
        lc0 = lcnt;
        room(2);
        st = tail;
        put(ERRA, 32'hEF);
        exp_cur = exp_cur + 8'd1;
        put(SB + 32'h8, {24'd0, exp_cur});
        hwr(3'd3, {24'd0, exp_cur});
        wait_stop();
        hrd(3'd5, v); chk("R10 second fault", {31'd0, v[1]}, 32'h1);
        hwr(3'd0, 32'h50);
        hrd(3'd5, v); chk("R10 disable clears error", {31'd0, v[1]}, 32'h0);
        hwr(3'd1, 32'(8*(st + 1)));
        hwr(3'd0, 32'h51);
        wait_stop();
        hrd(3'd2, v); chk("R4 index after disable recovery", v, {24'd0, exp_cur});
        chk("R10 no write logged for fault", 32'(lcnt), 32'(lc0));

        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule